// File: doc/BRIEF.md
# Hash-Chained Instruction Unmasking Sequencer

This block sits between instruction fetch and instruction decode in a small processor with 16-bit opcodes and 16-bit addresses. The opcodes in program memory are stored masked. The mask for each one comes from one secret accumulator, and the accumulator folds in every instruction that has executed so far. The program counter plays no part in the mask. A changed opcode, a skipped opcode or an illegal jump therefore leaves the accumulator wrong, and every later opcode then decrypts to garbage. One mechanism covers both instruction integrity and control-flow integrity.

For each fetched word the sequencer first checks whether the address carries multi-predecessor metadata, which arrives as a flag beside the fetch. If the flag is set, it sends the accumulator to an external polynomial evaluator and takes the returned value as the new state. If the flag is clear, a keyed mixing stub runs over the accumulator and the previous plaintext opcode. The sequencer then unmasks the word with a compressed copy of the accumulator and checks that the result is a legal opcode. A legal opcode is not passed to decode straight away. It is held until its successor has also decrypted to a legal opcode. An illegal opcode raises a sticky alarm and stops the sequencer.

An optional index mode adds the fetch address to each keyed update as a tweak. With the tweak, two successors of the same branch no longer share one state.

Top module: `hashchain_unmask_seq`

## Requirements
- R1: After reset the accumulator is loaded with the keyed mix of `iv` (data 0, tweak 0). While this runs, `busy` is high and `fetch_ready` is low. The first instruction after reset that has no metadata is unmasked with this value directly, and no further mix is run for it.
- R2: A fetch with `fetch_has_poly`=1 raises `poly_req` with `poly_arg` equal to the current accumulator. Until `poly_done`, `fetch_ready` stays low and `busy` stays low, so no keyed mix runs. The accumulator then becomes `poly_result`.
- R3: Any other fetch runs the keyed mix while `busy` is high. The mix uses seed = accumulator, data = previous plaintext opcode and MIX_ROUNDS rounds. Round i computes t = x ^ key ^ (i*0x9E37 mod 2^16), then x = rotl5(t) + (data ^ tweak).
- R4: The plaintext is the fetched word XOR c(acc), where c(a) = a ^ {a[7:0],a[15:8]} ^ 0x5A3C.
- R5: An opcode is legal when it is nonzero and its bits [15:12] are below VALID_CLASSES (default 12, so class 0x0 to 0xB).
- R6: An illegal plaintext raises `alarm`, which stays high until reset. After that, `fetch_ready`, `dec_valid` and `poly_req` stay low, and no held instruction is ever released.
- R7: Instruction n appears on `dec_op`/`dec_addr` with its own fetch address only after instruction n+1 has decrypted to a legal opcode. While `dec_ready` is low the output holds steady and no new fetch is accepted.
- R8: With `idx_mode`=1 the keyed-mix tweak is the fetch address. With `idx_mode`=0 the tweak is 0, so the fetch address has no effect on decryption.
- R9: While reset is asserted, `alarm`, `dec_valid`, `poly_req`, `fetch_ready` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key | input | 16 | Secret mixing key |
| iv | input | 16 | Initialization value for the accumulator |
| idx_mode | input | 1 | Use the fetch address as keyed-mix tweak |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_ready | output | 1 | Sequencer accepts a fetch word |
| fetch_addr | input | 16 | Address of the offered word |
| fetch_ciph | input | 16 | Masked opcode |
| fetch_has_poly | input | 1 | Address carries multi-predecessor metadata |
| poly_req | output | 1 | Polynomial evaluation requested |
| poly_arg | output | 16 | Accumulator passed to the evaluator |
| poly_done | input | 1 | Evaluation finished |
| poly_result | input | 16 | Evaluated polynomial value |
| dec_valid | output | 1 | Released opcode valid |
| dec_ready | input | 1 | Decode accepts the opcode |
| dec_op | output | 16 | Released plaintext opcode |
| dec_addr | output | 16 | Address of the released opcode |
| alarm | output | 1 | Sticky attack alarm |
| busy | output | 1 | Keyed mix in progress |

## Verification
The hardest case to reach from the ports is an instruction that has been decrypted and held but must never be released, because its successor turns out illegal. The bench builds each masked word from its own model of the accumulator chain. It then corrupts chosen successors with a mask that pushes the class field out of range, and it also sweeps every class value for the second instruction. It watches `dec_valid` right up to the alarm. A second hard case is a word fetched at an address other than the one it was masked for. The bench creates this in both index modes and predicts the result from the tweak rule.

// File: rtl/cus_pkg.sv
package cus_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_BOOT,
    ST_IDLE,
    ST_POLY,
    ST_MIX,
    ST_CHECK,
    ST_EMIT,
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/cus_mixer.sv
// Keyed iterated-round mixing stub, one round per clock.
module cus_mixer #(
  parameter int W = 16,
  parameter int ROUNDS = 4,
  parameter logic [W-1:0] ROUND_CONST = 16'h9E37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] key,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] data,
  input  logic [W-1:0] tweak,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int RCW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam int ROT = 5;
  localparam logic [RCW-1:0] LAST = RCW'(ROUNDS - 1);

  logic [W-1:0]   x_q, x_d, dt_q, dt_d, rc, t, x_round;
  logic [RCW-1:0] rnd_q, rnd_d;
  logic           busy_q, busy_d, done_q, done_d;

  always_comb begin
    rc      = W'(rnd_q) * ROUND_CONST;
    t       = x_q ^ key ^ rc;
    x_round = {t[W-ROT-1:0], t[W-1:W-ROT]} + dt_q;
  end

  always_comb begin
    x_d    = x_q;
    dt_d   = dt_q;
    rnd_d  = rnd_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      x_d    = seed;
      dt_d   = data ^ tweak;
      rnd_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      x_d = x_round;
      if (rnd_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        rnd_d = rnd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      dt_q   <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      x_q    <= x_d;
      dt_q   <= dt_d;
      rnd_q  <= rnd_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = x_q;

  // R3
  mix_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R3
  mix_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/cus_compress.sv
// Folds the accumulator into an instruction-width keystream word.
module cus_compress #(
  parameter int OPW = 16,
  parameter logic [OPW-1:0] MASK = 16'h5A3C
) (
  input  logic [OPW-1:0] value,
  output logic [OPW-1:0] digest
);
  localparam int HALF = OPW / 2;
  assign digest = value ^ {value[HALF-1:0], value[OPW-1:HALF]} ^ MASK;
endmodule

// File: rtl/cus_opcheck.sv
// Legal-opcode decoder: nonzero and class field below the limit.
module cus_opcheck #(
  parameter int OPW = 16,
  parameter int VALID_CLASSES = 12
) (
  input  logic [OPW-1:0] op,
  output logic           ok
);
  localparam int CLW = 4;
  logic [CLW-1:0] cls;
  assign cls = op[OPW-1 -: CLW];
  assign ok  = (op != '0) && ({1'b0, cls} < (CLW+1)'(VALID_CLASSES));
endmodule

// File: rtl/hashchain_unmask_seq.sv
module hashchain_unmask_seq
  import cus_pkg::*;
#(
  parameter int OPW = 16,
  parameter int AW = 16,
  parameter int MIX_ROUNDS = 4,
  parameter int VALID_CLASSES = 12,
  parameter logic [OPW-1:0] COMP_MASK = 16'h5A3C,
  parameter logic [OPW-1:0] ROUND_CONST = 16'h9E37
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] key,
  input  logic [OPW-1:0] iv,
  input  logic           idx_mode,
  input  logic           fetch_valid,
  output logic           fetch_ready,
  input  logic [AW-1:0]  fetch_addr,
  input  logic [OPW-1:0] fetch_ciph,
  input  logic           fetch_has_poly,
  output logic           poly_req,
  output logic [OPW-1:0] poly_arg,
  input  logic           poly_done,
  input  logic [OPW-1:0] poly_result,
  output logic           dec_valid,
  input  logic           dec_ready,
  output logic [OPW-1:0] dec_op,
  output logic [AW-1:0]  dec_addr,
  output logic           alarm,
  output logic           busy
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  seq_state_e     state_q, state_d;
  logic [OPW-1:0] acc_q, acc_d, prev_q, prev_d, ciph_q, ciph_d;
  logic [OPW-1:0] hold_op_q, hold_op_d;
  logic [AW-1:0]  addr_q, addr_d, hold_addr_q, hold_addr_d;
  logic           first_q, first_d, hold_vld_q, hold_vld_d, alarm_q, alarm_d;

  logic           mix_start, mix_busy, mix_done;
  logic [OPW-1:0] mix_seed, mix_data, mix_tweak, mix_res;
  logic [OPW-1:0] keystream, plain;
  logic           op_ok;

  cus_mixer #(.W(OPW), .ROUNDS(MIX_ROUNDS), .ROUND_CONST(ROUND_CONST)) u_mix (
    .clk(clk), .rst_n(rst_sn), .start(mix_start), .key(key), .seed(mix_seed),
    .data(mix_data), .tweak(mix_tweak), .busy(mix_busy), .done(mix_done),
    .result(mix_res)
  );

  cus_compress #(.OPW(OPW), .MASK(COMP_MASK)) u_comp (
    .value(acc_q), .digest(keystream)
  );

  assign plain = ciph_q ^ keystream;

  cus_opcheck #(.OPW(OPW), .VALID_CLASSES(VALID_CLASSES)) u_chk (
    .op(plain), .ok(op_ok)
  );

  always_comb begin
    state_d     = state_q;
    acc_d       = acc_q;
    prev_d      = prev_q;
    ciph_d      = ciph_q;
    addr_d      = addr_q;
    first_d     = first_q;
    hold_vld_d  = hold_vld_q;
    hold_op_d   = hold_op_q;
    hold_addr_d = hold_addr_q;
    alarm_d     = alarm_q;
    mix_start   = 1'b0;
    mix_seed    = acc_q;
    mix_data    = prev_q;
    mix_tweak   = idx_mode ? OPW'(fetch_addr) : '0;
    unique case (state_q)
      ST_START: begin
        mix_start = 1'b1;
        mix_seed  = iv;
        mix_data  = '0;
        mix_tweak = '0;
        state_d   = ST_BOOT;
      end
      ST_BOOT: begin
        if (mix_done) begin
          acc_d   = mix_res;
          first_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (fetch_valid) begin
          ciph_d = fetch_ciph;
          addr_d = fetch_addr;
          if (fetch_has_poly) begin
            state_d = ST_POLY;
          end else if (first_q) begin
            state_d = ST_CHECK;
          end else begin
            mix_start = 1'b1;
            state_d   = ST_MIX;
          end
        end
      end
      ST_POLY: begin
        if (poly_done) begin
          acc_d   = poly_result;
          state_d = ST_CHECK;
        end
      end
      ST_MIX: begin
        if (mix_done) begin
          acc_d   = mix_res;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!op_ok) begin
          alarm_d = 1'b1;
          state_d = ST_HALT;
        end else begin
          prev_d  = plain;
          first_d = 1'b0;
          if (hold_vld_q) begin
            state_d = ST_EMIT;
          end else begin
            hold_vld_d  = 1'b1;
            hold_op_d   = plain;
            hold_addr_d = addr_q;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_EMIT: begin
        if (dec_ready) begin
          hold_op_d   = prev_q;
          hold_addr_d = addr_q;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q     <= ST_START;
      acc_q       <= '0;
      prev_q      <= '0;
      ciph_q      <= '0;
      addr_q      <= '0;
      first_q     <= 1'b1;
      hold_vld_q  <= 1'b0;
      hold_op_q   <= '0;
      hold_addr_q <= '0;
      alarm_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      acc_q       <= acc_d;
      prev_q      <= prev_d;
      ciph_q      <= ciph_d;
      addr_q      <= addr_d;
      first_q     <= first_d;
      hold_vld_q  <= hold_vld_d;
      hold_op_q   <= hold_op_d;
      hold_addr_q <= hold_addr_d;
      alarm_q     <= alarm_d;
    end
  end

  assign fetch_ready = (state_q == ST_IDLE);
  assign poly_req    = (state_q == ST_POLY);
  assign poly_arg    = acc_q;
  assign dec_valid   = (state_q == ST_EMIT);
  assign dec_op      = hold_op_q;
  assign dec_addr    = hold_addr_q;
  assign alarm       = alarm_q;
  assign busy        = mix_busy;

  // R6
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    alarm_q |=> alarm_q);
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    alarm_q |-> !fetch_ready && !dec_valid && !poly_req);
  // R7
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_op) && $stable(dec_addr));
  // R2
  poly_stall_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    poly_req |-> !busy && !fetch_ready);
  // R2
  poly_arg_stable_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    poly_req && !poly_done |=> poly_req && $stable(poly_arg));
endmodule

// File: tb/tb_hashchain_unmask_seq.sv
module tb_hashchain_unmask_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROUNDS = 4;
  localparam logic [15:0] KEY = 16'h7E91;
  localparam logic [15:0] IV  = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n, idx_mode, fetch_valid, fetch_has_poly, poly_done, dec_ready;
  logic [15:0] fetch_addr, fetch_ciph, poly_result;
  logic        fetch_ready, poly_req, dec_valid, alarm, busy;
  logic [15:0] poly_arg, dec_op, dec_addr;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_acc, m_prev, m_hold_op, m_hold_addr;
  bit          m_first, m_hold_vld, m_halted;

  always #(CLK_PERIOD/2) clk = ~clk;

  hashchain_unmask_seq #(.MIX_ROUNDS(ROUNDS)) dut (
    .clk(clk), .rst_n(rst_n), .key(KEY), .iv(IV), .idx_mode(idx_mode),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_ciph(fetch_ciph), .fetch_has_poly(fetch_has_poly), .poly_req(poly_req),
    .poly_arg(poly_arg), .poly_done(poly_done), .poly_result(poly_result),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_op(dec_op),
    .dec_addr(dec_addr), .alarm(alarm), .busy(busy)
  );

  function automatic logic [15:0] f_mix(input logic [15:0] seed, input logic [15:0] data,
                                         input logic [15:0] tweak);
    logic [15:0] x, t, rc;
    x = seed;
    for (int i = 0; i < ROUNDS; i++) begin
      rc = 16'(i * 32'h9E37);
      t  = x ^ KEY ^ rc;
      x  = {t[10:0], t[15:11]} + (data ^ tweak);
    end
    return x;
  endfunction

  function automatic logic [15:0] f_comp(input logic [15:0] a);
    return a ^ {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic bit f_legal(input logic [15:0] op);
    return (op != 16'h0000) && (op[15:12] < 4'd12);
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode);
    int n;
    bit saw_busy;
    idx_mode = mode; fetch_valid = 1'b0; fetch_has_poly = 1'b0;
    poly_done = 1'b0; dec_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    chk(!alarm && !dec_valid && !poly_req && !fetch_ready && !busy, "R9 reset outputs",
        {27'd0, alarm, dec_valid, poly_req, fetch_ready, busy}, 32'd0);
    rst_n = 1'b1;
    saw_busy = 1'b0; n = 0;
    while (!fetch_ready && n < 200) begin
      @(negedge clk);
      if (busy) saw_busy = 1'b1;
      n++;
    end
    // R1: the boot mix runs before the first fetch is accepted
    chk(fetch_ready && saw_busy, "R1 boot mix before fetch", {30'd0, fetch_ready, saw_busy}, 32'd3);
    m_acc = f_mix(IV, 16'h0000, 16'h0000);
    m_prev = 16'h0000; m_first = 1'b1; m_hold_vld = 1'b0; m_halted = 1'b0;
    m_hold_op = 16'h0; m_hold_addr = 16'h0;
  endtask

  // addr: fetch address; enc_addr: address whose tweak was used to mask the word
  task automatic step(input logic [15:0] addr, input logic [15:0] enc_addr,
                      input logic [15:0] plain, input logic [15:0] flip, input bit has_poly,
                      input logic [15:0] pval, input int stall);
    logic [15:0] acc_enc, acc_run, ciph, got;
    int n;
    bit leaked;
    if (m_halted) return;
    if (has_poly)     acc_enc = pval;
    else if (m_first) acc_enc = m_acc;
    else              acc_enc = f_mix(m_acc, m_prev, idx_mode ? enc_addr : 16'h0);
    if (has_poly)     acc_run = pval;
    else if (m_first) acc_run = m_acc;
    else              acc_run = f_mix(m_acc, m_prev, idx_mode ? addr : 16'h0);
    ciph = plain ^ f_comp(acc_enc) ^ flip;
    got  = ciph ^ f_comp(acc_run);
    n = 0;
    while (!fetch_ready && n < 500) begin @(negedge clk); n++; end
    fetch_valid = 1'b1; fetch_addr = addr; fetch_ciph = ciph; fetch_has_poly = has_poly;
    @(negedge clk);
    fetch_valid = 1'b0;
    if (has_poly) begin
      // R2: request carries the old accumulator, no keyed mix, fetch stalled
      chk(poly_req && poly_arg == m_acc && !busy && !fetch_ready, "R2 poly request",
          {poly_arg, 12'd0, poly_req, busy, fetch_ready, 1'b0}, {m_acc, 16'h0008});
      repeat (2) @(negedge clk);
      chk(poly_req && !fetch_ready, "R2 stall while pending", {30'd0, poly_req, fetch_ready}, 32'd2);
      poly_done = 1'b1; poly_result = pval;
      @(negedge clk);
      poly_done = 1'b0;
    end else if (!m_first) begin
      // R3: keyed mix runs for non-entry, non-metadata fetch
      chk(busy, "R3 mix busy", {31'd0, busy}, 32'd1);
    end
    m_acc = acc_run;
    leaked = 1'b0;
    if (!f_legal(got)) begin
      n = 0;
      while (!alarm && n < 40) begin
        if (dec_valid) leaked = 1'b1;
        @(negedge clk); n++;
      end
      // R5 R6: illegal plaintext raises alarm, held instruction not released
      chk(alarm && !leaked, "R5 R6 alarm on illegal opcode", {16'd0, got}, {16'd0, got});
      fetch_valid = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!alarm || fetch_ready || dec_valid || poly_req) leaked = 1'b1;
      end
      fetch_valid = 1'b0;
      chk(!leaked, "R6 alarm sticky and halted", {31'd0, leaked}, 32'd0);
      m_halted = 1'b1;
      return;
    end
    if (m_hold_vld) begin
      dec_ready = (stall == 0);
      n = 0;
      while (!dec_valid && n < 100) begin @(negedge clk); n++; end
      // R4 R7: previous instruction released with its own address
      chk(dec_valid && dec_op == m_hold_op && dec_addr == m_hold_addr, "R4 R7 released opcode",
          {dec_op, dec_addr}, {m_hold_op, m_hold_addr});
      if (stall > 0) begin
        repeat (stall) @(negedge clk);
        chk(dec_valid && dec_op == m_hold_op && !fetch_ready, "R7 hold under backpressure",
            {dec_op, 15'd0, fetch_ready}, {m_hold_op, 16'd0});
        dec_ready = 1'b1;
      end
      @(negedge clk);
      m_hold_op = got; m_hold_addr = addr;
    end else begin
      n = 0;
      while (!fetch_ready && n < 100) begin
        if (dec_valid) leaked = 1'b1;
        @(negedge clk); n++;
      end
      // R7: the first legal instruction is held back
      chk(!leaked && fetch_ready, "R7 first instruction held", {31'd0, leaked}, 32'd0);
      m_hold_vld = 1'b1; m_hold_op = got; m_hold_addr = addr;
    end
    chk(!alarm, "R5 legal opcode no alarm", {31'd0, alarm}, 32'd0);
    m_prev = got; m_first = 1'b0;
  endtask

  task automatic run_program(input int count);
    logic [15:0] op;
    for (int k = 0; k < count; k++) begin
      op = {4'(k % 12), 12'(k * 37 + 5) | 12'h001};
      step(16'h0200 + 16'(2 * k), 16'h0200 + 16'(2 * k), op, 16'h0000, (k % 5) == 3,
           16'(k * 32'h1F3B) ^ 16'hA5A5, ((k % 7) == 2) ? 3 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fetch_addr = 16'h0; fetch_ciph = 16'h0; poly_result = 16'h0;
    // R1 R3 R4 R7 in both tweak modes
    do_reset(1'b0);
    run_program(24);
    do_reset(1'b1);
    run_program(24);
    // R8: word fetched at a different address than it was masked for
    do_reset(1'b0);
    step(16'h0100, 16'h0100, 16'h1111, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0300, 16'h0310, 16'h2345, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0302, 16'h0302, 16'h0042, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0304, 16'h0304, 16'h0043, 16'h0, 1'b0, 16'h0, 0);
    do_reset(1'b1);
    step(16'h0100, 16'h0100, 16'h1111, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0300, 16'h0310, 16'h2345, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0302, 16'h0302, 16'h0042, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0304, 16'h0304, 16'h0043, 16'h0, 1'b0, 16'h0, 0);
    // R5: sweep of every class value for the second instruction
    for (int c = 0; c < 16; c++) begin
      do_reset(c[0]);
      step(16'h0400, 16'h0400, 16'h0ABC, 16'h0, 1'b0, 16'h0, 0);
      step(16'h0402, 16'h0402, {4'(c), 12'h5A1}, 16'h0, 1'b0, 16'h0, 0);
      step(16'h0404, 16'h0404, 16'h0007, 16'h0, 1'b0, 16'h0, 0);
    end
    // R5: zero opcode, top legal boundary, and an illegal entry instruction
    do_reset(1'b0);
    step(16'h0500, 16'h0500, 16'hBFFF, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0502, 16'h0502, 16'h0001, 16'h0, 1'b0, 16'h0, 0);
    step(16'h0504, 16'h0504, 16'h0000, 16'h0, 1'b0, 16'h0, 0);
    do_reset(1'b0);
    step(16'h0600, 16'h0600, 16'hFFFF, 16'h0, 1'b0, 16'h0, 0);
    // R6: tampered ciphertext in the middle of a run, and after a metadata step
    do_reset(1'b0);
    run_program(5);
    step(16'h0700, 16'h0700, 16'h2345, 16'hE000, 1'b0, 16'h0, 0);
    do_reset(1'b1);
    run_program(3);
    step(16'h0800, 16'h0800, 16'h3456, 16'hF000, 1'b1, 16'h4C1D, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule